// File: doc/BRIEF.md
# Pipelined Fixed-Point Multiplier with Per-Operand Signedness

This block multiplies two 32-bit fixed-point operands and produces the full 64-bit product. The product is delivered as an upper and a lower 32-bit half. Each operand has its own select that marks it as two's-complement or unsigned. The block can therefore form unsigned products, signed products and mixed signed-by-unsigned products. A mixed product always comes out in two's-complement form.

An output-shift select moves the whole product left by one bit, with a zero entering the least significant bit. For signed fractional data this removes the redundant sign bit. All selects are sampled on the same rising edge as their operands and travel down the pipeline with them. A new operation may enter on every cycle.

A valid flag marks each result, which appears exactly three clock edges after its operands were accepted. An asynchronous active-low reset clears the valid and control pipeline. It leaves the data registers untouched.

Top module: `fxmul_top`

## Requirements
- R1: With both signedness selects low (0 = unsigned), the 64-bit output equals the unsigned product of the two operands.
- R2: With both signedness selects high (1 = two's-complement), the output is the 64-bit two's-complement product.
- R3: With exactly one select high, the operand with the high select is taken as signed and the other as unsigned, and the product is given in two's-complement form.
- R4: With the shift select high, the output is the product moved left one place: output bit i+1 holds product bit i, product bit 63 is dropped, and output bit 0 is 0.
- R5: A result appears on the outputs, with the valid flag high, exactly three rising edges after the edge that sampled its operands with the input valid high. Operations may be issued on consecutive cycles.
- R6: The signedness and shift selects belong to the operation they were sampled with. Changing them on later cycles does not alter earlier results still in flight.
- R7: For a signed-by-signed product without shift, output bits 63 and 62 are equal, except when both operands are 0x80000000; that product is 0x4000000000000000.
- R8: Asserting the reset drives the valid flag low at once, without a clock edge. The two output halves keep their last values through the reset.
- R9: On a cycle without a new result, the valid flag is low and both output halves hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands and selects are valid this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| signA | input | 1 | 1: opA is two's-complement, 0: unsigned |
| signB | input | 1 | 1: opB is two's-complement, 0: unsigned |
| shiftLeft | input | 1 | 1: shift the product left by one before output |
| prodHi | output | 32 | Upper half of the product (bits 63..32) |
| prodLo | output | 32 | Lower half of the product (bits 31..0) |
| outValid | output | 1 | Result on prodHi/prodLo is new this cycle |

## Verification
The bench builds the block with its default width of 32 bits. This width makes the hand-derived corners reachable, such as 0x80000000 squared and all-ones operands in each signedness combination. At this width the bench can also compute a 128-bit reference product directly. Random issue gaps and select changes on back-to-back cycles exercise the pairing of each select with its own operands. A reset applied after the pipeline has drained shows that the output halves are retained.

// File: rtl/fxmul_pkg.sv
package fxmul_pkg;
  typedef struct packed {
    logic loadIn;
    logic loadProd;
    logic loadOut;
    logic extA;
    logic extB;
    logic shiftOut;
  } mulStrobe_t;
endpackage

// File: rtl/fxmul_ctrl.sv
module fxmul_ctrl
  import fxmul_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       signA,
  input  logic       signB,
  input  logic       shiftLeft,
  output mulStrobe_t strobe,
  output logic       outValid
);
  logic [STAGES-1:0] vldPipe;
  logic              sgnAReg, sgnBReg;
  logic              shStage1, shStage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldPipe <= '0;
    end else begin
      vldPipe <= {vldPipe[STAGES-2:0], inValid};
    end
  end

  // selects ride with their operands; reset clears them
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sgnAReg  <= 1'b0;
      sgnBReg  <= 1'b0;
      shStage1 <= 1'b0;
      shStage2 <= 1'b0;
    end else begin
      if (inValid) begin
        sgnAReg  <= signA;
        sgnBReg  <= signB;
        shStage1 <= shiftLeft;
      end
      if (vldPipe[0]) begin
        shStage2 <= shStage1;
      end
    end
  end

  always_comb begin
    strobe.loadIn   = inValid;
    strobe.loadProd = vldPipe[0];
    strobe.loadOut  = vldPipe[1];
    strobe.extA     = sgnAReg;
    strobe.extB     = sgnBReg;
    strobe.shiftOut = shStage2;
  end

  assign outValid = vldPipe[STAGES-1];
endmodule

// File: rtl/fxmul_dp.sv
module fxmul_dp
  import fxmul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  mulStrobe_t       strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] prodHi,
  output logic [WIDTH-1:0] prodLo
);
  localparam int PW = 2 * WIDTH;
  localparam int XW = WIDTH + 1;

  logic [WIDTH-1:0]     aReg, bReg;
  logic signed [XW-1:0] aExt, bExt;
  logic signed [2*XW-1:0] fullProd;
  logic [PW-1:0]        prodReg, outReg, shifted;

  // operand registers: no reset, only loaded with new work
  always_ff @(posedge clk) begin
    if (strobe.loadIn) begin
      aReg <= opA;
      bReg <= opB;
    end
  end

  always_comb begin
    aExt     = {strobe.extA & aReg[WIDTH-1], aReg};
    bExt     = {strobe.extB & bReg[WIDTH-1], bReg};
    fullProd = aExt * bExt;
  end

  always_ff @(posedge clk) begin
    if (strobe.loadProd) prodReg <= fullProd[PW-1:0];
  end

  assign shifted = strobe.shiftOut ? {prodReg[PW-2:0], 1'b0} : prodReg;

  always_ff @(posedge clk) begin
    if (strobe.loadOut) outReg <= shifted;
  end

  assign prodHi = outReg[PW-1:WIDTH];
  assign prodLo = outReg[WIDTH-1:0];
endmodule

// File: rtl/fxmul_top.sv
module fxmul_top
  import fxmul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             signA,
  input  logic             signB,
  input  logic             shiftLeft,
  output logic [WIDTH-1:0] prodHi,
  output logic [WIDTH-1:0] prodLo,
  output logic             outValid
);
  mulStrobe_t strobe;

  fxmul_ctrl #(.STAGES(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .signA(signA), .signB(signB), .shiftLeft(shiftLeft),
    .strobe(strobe), .outValid(outValid)
  );

  fxmul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .strobe(strobe), .opA(opA), .opB(opB),
    .prodHi(prodHi), .prodLo(prodLo)
  );
endmodule

// File: rtl/fxmul_chk.sv
module fxmul_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             signA,
  input logic             signB,
  input logic             shiftLeft,
  input logic [WIDTH-1:0] prodHi,
  input logic [WIDTH-1:0] prodLo,
  input logic             outValid
);
  localparam logic [WIDTH-1:0] MOSTNEG = {1'b1, {(WIDTH-1){1'b0}}};

  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 outValid);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##3 !outValid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable({prodHi, prodLo}));

  p_zero_lsb_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(inValid, 3) && $past(shiftLeft, 3)) |-> (prodLo[0] == 1'b0));

  p_sign_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(inValid && signA && signB && !shiftLeft, 3)
     && !($past(opA, 3) == MOSTNEG && $past(opB, 3) == MOSTNEG))
    |-> (prodHi[WIDTH-1] == prodHi[WIDTH-2]));

  p_unsigned_r1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(inValid && !signA && !signB && !shiftLeft, 3))
    |-> ({prodHi, prodLo} == {{WIDTH{1'b0}}, $past(opA, 3)} * {{WIDTH{1'b0}}, $past(opB, 3)}));
endmodule

bind fxmul_top fxmul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
  .signA(signA), .signB(signB), .shiftLeft(shiftLeft),
  .prodHi(prodHi), .prodLo(prodLo), .outValid(outValid)
);

// File: tb/fxmul_top_tb.sv
module fxmul_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        signA = 1'b0, signB = 1'b0, shiftLeft = 1'b0;
  logic [31:0] prodHi, prodLo;
  logic        outValid;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  bit          expV [8];
  logic [63:0] expD [8];
  bit          expR7 [8];
  string       expTag [8];
  logic [63:0] lastOut = '0;
  bit          haveLast = 0;

  always #5 clk = ~clk;

  fxmul_top u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .signA(signA), .signB(signB), .shiftLeft(shiftLeft),
    .prodHi(prodHi), .prodLo(prodLo), .outValid(outValid)
  );

  function automatic logic [63:0] golden(logic [31:0] a, logic [31:0] b,
                                         logic sa, logic sb, logic sh);
    logic [127:0] ea, eb, p;
    ea = sa ? {{96{a[31]}}, a} : {96'b0, a};
    eb = sb ? {{96{b[31]}}, b} : {96'b0, b};
    p  = ea * eb;
    return sh ? {p[62:0], 1'b0} : p[63:0];
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] a, logic [31:0] b,
                      logic sa, logic sb, logic sh, string tag);
    int s;
    @(negedge clk);
    if (cyc >= 3) begin
      s = (cyc - 3) % 8;
      if (expV[s]) begin
        check(outValid == 1'b1, {expTag[s], " R5 valid"}, 64'(outValid), 64'd1);
        check({prodHi, prodLo} == expD[s], expTag[s], {prodHi, prodLo}, expD[s]);
        if (expR7[s])
          check(prodHi[31] == prodHi[30], "R7 top bits", {prodHi, prodLo}, expD[s]);
        lastOut = expD[s];
        haveLast = 1;
      end else begin
        check(outValid == 1'b0, "R9 valid low", 64'(outValid), 64'd0);
        if (haveLast)
          check({prodHi, prodLo} == lastOut, "R9 hold", {prodHi, prodLo}, lastOut);
      end
    end
    s = cyc % 8;
    expV[s]   = v;
    expD[s]   = golden(a, b, sa, sb, sh);
    expR7[s]  = v && sa && sb && !sh && !(a == 32'h8000_0000 && b == 32'h8000_0000);
    expTag[s] = tag;
    inValid = v; opA = a; opB = b; signA = sa; signB = sb; shiftLeft = sh;
    cyc++;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8 reset valid", 64'(outValid), 64'd0);
    rstN = 1'b1;

    // directed corners
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, "R1 unsigned max");
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0, "R2 signed -1*-1");
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, "R3 mixed A signed");
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 0, "R3 mixed B signed");
    step(1, 32'h8000_0000, 32'h8000_0000, 1, 1, 0, "R7 most negative squared");
    step(1, 32'h8000_0000, 32'h8000_0000, 1, 1, 1, "R4 shift most negative");
    step(1, 32'h7FFF_FFFF, 32'h8000_0000, 1, 1, 1, "R4 shift signed");
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1, "R4 shift drops bit 63");
    step(1, 32'h1234_5678, 32'h9ABC_DEF0, 1, 0, 0, "R6 selects per op");
    step(1, 32'h1234_5678, 32'h9ABC_DEF0, 0, 1, 1, "R6 selects per op");
    step(1, 32'h1234_5678, 32'h9ABC_DEF0, 1, 1, 0, "R6 selects per op");
    step(0, 32'hDEAD_BEEF, 32'h0000_0002, 1, 1, 1, "R9 idle");
    step(0, 32'h0, 32'h0, 0, 0, 0, "R9 idle");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      logic v, sa, sb, sh;
      a = $urandom; b = $urandom;
      v = ($urandom % 4) != 0;
      sa = $urandom[0]; sb = $urandom[0]; sh = $urandom[0];
      if (($urandom % 8) == 0) a = 32'h8000_0000;
      step(v, a, b, sa, sb, sh, sa && sb ? "R2 random" : (sa || sb ? "R3 random" : "R1 random"));
    end
    repeat (4) step(0, 32'h0, 32'h0, 0, 0, 0, "R9 drain");

    // asynchronous reset after drain: valid low at once, data retained
    @(negedge clk);
    #1 rstN = 1'b0;
    #1;
    check(outValid == 1'b0, "R8 async valid clear", 64'(outValid), 64'd0);
    check({prodHi, prodLo} == lastOut, "R8 data retained", {prodHi, prodLo}, lastOut);
    @(negedge clk);
    check({prodHi, prodLo} == lastOut, "R8 data retained", {prodHi, prodLo}, lastOut);
    rstN = 1'b1;
    for (int k = 0; k < 8; k++) expV[k] = 0;
    cyc = 0;
    step(1, 32'h0000_0003, 32'hFFFF_FFFD, 0, 1, 0, "R3 after reset");
    step(1, 32'h4000_0000, 32'h4000_0000, 1, 1, 1, "R4 after reset");
    repeat (5) step(0, 32'h0, 32'h0, 0, 0, 0, "R9 final drain");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule